// File: doc/BRIEF.md
# Two-Wire Bus Master Transmitter with Status-Code Handshake

This block is a byte-level master transmitter for an open-drain two-wire serial bus (I2C-style). A host programs it through three small registers: a control register, a data register, and a read-only status output. The block is event driven. It generates a START, sends a byte and samples the acknowledge bit. Then it stops, raises an interrupt flag, and reports a fixed 8-bit status code for what just happened. While it waits, it keeps SCL low so that the bus stalls until the host answers.

The host answers by loading the data register, if needed, and writing the control register with the flag bit at 0. The start and stop bits written with it select the next action: send another byte, send a repeated START, send a STOP, or send a STOP and then a fresh START. If the block loses the bus to another master, it lets go of both lines at once and reports the loss. It can then either go idle or queue a new START for the moment the bus is free again. An address byte with the read bit set is not served here. The block only signals that the receiver role would take over.

Bit timing comes from one fixed prescaler. Every bit lasts four quarter-periods of `QDIV` clock cycles.

Top module: `i2cm_xmit`

## Requirements
- R1: After reset the status reads F8h, the control register reads 0, neither bus line is driven low, and the receiver indication is low.
- R2: Control register layout (host write address 0): bit 3 start, bit 2 stop, bit 1 interrupt flag, bit 0 acknowledge enable. Data register is write address 1. The host can clear the flag by writing 0 to it; writing 1 to the flag never sets it or keeps the bus stalled any longer.
- R3: With start=1 and the flag clear in idle, the block waits for a free bus, sends a START, and then reports 08h with the flag set.
- R4: In status 08h or 10h, clearing the flag sends the data register as an address byte, most significant bit first, whatever the start and stop bits hold.
- R5: After an address byte the status is 18h on ACK and 20h on NOT ACK. After a data byte it is 28h on ACK and 30h on NOT ACK.
- R6: In 18h, 20h, 28h and 30h, clearing the flag acts on {start,stop}: 00 sends the data register as a data byte, 10 sends a repeated START (status 10h), 01 sends a STOP and goes idle, 11 sends a STOP and then a START once the bus is free (status 08h).
- R7: Whenever a STOP is issued, the hardware clears the stop bit.
- R8: While the flag is set and the status is not 38h, the block holds SCL low. Whenever the flag is clear, the status reads F8h.
- R9: An address byte whose bit 0 is 1 ends with the receiver indication high, the flag clear, status F8h and SCL held low. It stays that way until the host requests a STOP, which drops the indication.
- R10: If the block releases SDA for a 1 bit but samples SDA low while SCL is high, it releases both lines at once and reports 38h.
- R11: In 38h, clearing the flag with start=0 enters idle. With start=1 it waits until a STOP has been seen on the bus, followed by one bit period of idle, and then sends a START (08h).
- R12: The acknowledge enable bit is stored and can be read back, but it has no effect on the bus or on the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 1 | 0 selects control, 1 selects data |
| wr_data | input | 8 | Host write value |
| status_o | output | 8 | Status code |
| ctrl_o | output | 4 | Control register readback |
| irq_o | output | 1 | Interrupt flag |
| rx_mode_o | output | 1 | Receiver role requested by an address with the read bit set |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
The bound assertions check four properties on every cycle. A raised flag carries only one of the seven legal codes. A stalled transfer keeps SCL low. A loss of arbitration leaves both lines released. The receiver hand-off keeps the clock held with the flag clear. Other behaviour needs a bus model, so only the bench scenarios can show it. This covers the order of codes through a whole session, each {start,stop} choice, the acknowledge outcome sampled from a responding target, the bytes that reach that target, and the automatic clearing of the stop bit. It also covers the wait for a free bus after a lost arbitration, which requires a second driver to hold SDA and then let go.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [3:0] {
        S_IDLE     = 4'd0,
        S_WAITFREE = 4'd1,
        S_START    = 4'd2,
        S_HOLD     = 4'd3,
        S_SEND     = 4'd4,
        S_STOP     = 4'd5,
        S_LOST     = 4'd6,
        S_RXPARK   = 4'd7
    } fsm_e;

    localparam logic [7:0] ST_START  = 8'h08;
    localparam logic [7:0] ST_RSTART = 8'h10;
    localparam logic [7:0] ST_AACK   = 8'h18;
    localparam logic [7:0] ST_ANACK  = 8'h20;
    localparam logic [7:0] ST_DACK   = 8'h28;
    localparam logic [7:0] ST_DNACK  = 8'h30;
    localparam logic [7:0] ST_LOST   = 8'h38;
    localparam logic [7:0] ST_NONE   = 8'hF8;

    localparam int CB_ACK   = 0;
    localparam int CB_FLAG  = 1;
    localparam int CB_STOP  = 2;
    localparam int CB_START = 3;

    typedef struct packed {
        fsm_e       st;
        logic [1:0] ph;
        logic [3:0] bidx;
        logic [7:0] shreg;
        logic       is_addr;
        logic       rd_addr;
        logic       ackd;
        logic       rep;
        logic [7:0] code;
        logic [3:0] ctrl;
        logic [7:0] data;
        logic       scl_oe;
        logic       sda_oe;
        logic       rx;
    } xmit_t;

endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
    parameter int QDIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon #(
    parameter int IDLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic free_o
);
    localparam int CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(IDLE_CYC);

    typedef struct packed {
        logic          pscl;
        logic          psda;
        logic          busy;
        logic [CW-1:0] cnt;
    } mon_t;

    mon_t d, q;
    logic start_seen, stop_seen;

    always_comb begin
        d = q;
        start_seen = q.pscl && scl_i && q.psda && !sda_i;
        stop_seen  = q.pscl && scl_i && !q.psda && sda_i;
        d.pscl = scl_i;
        d.psda = sda_i;
        if (start_seen) begin
            d.busy = 1'b1;
            d.cnt  = '0;
        end else if (stop_seen) begin
            d.busy = 1'b0;
            d.cnt  = '0;
        end else if (q.busy) begin
            d.cnt = '0;
        end else if (q.cnt != CMAX) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{pscl: 1'b1, psda: 1'b1, busy: 1'b0, cnt: '0};
        else        q <= d;
    end

    assign free_o = !q.busy && (q.cnt == CMAX);
endmodule

// File: rtl/i2cm_xmit.sv
module i2cm_xmit
    import i2cm_pkg::*;
#(
    parameter int QDIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] status_o,
    output logic [3:0] ctrl_o,
    output logic       irq_o,
    output logic       rx_mode_o,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o
);
    localparam int IDLE_CYC = 4 * QDIV;

    logic tick, bus_free;
    xmit_t d, q;

    i2cm_qtick #(.QDIV(QDIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    i2cm_busmon #(.IDLE_CYC(IDLE_CYC)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .free_o(bus_free)
    );

    always_comb begin
        d = q;
        // host register writes; flag may only be cleared
        if (wr_en) begin
            if (wr_addr) begin
                d.data = wr_data;
            end else begin
                d.ctrl[CB_START] = wr_data[CB_START];
                d.ctrl[CB_STOP]  = wr_data[CB_STOP];
                d.ctrl[CB_ACK]   = wr_data[CB_ACK];
                d.ctrl[CB_FLAG]  = q.ctrl[CB_FLAG] & wr_data[CB_FLAG];
            end
        end
        // hardware updates below take priority over a same-cycle write
        case (q.st)
            S_IDLE: begin
                d.scl_oe = 1'b0;
                d.sda_oe = 1'b0;
                if (q.ctrl[CB_START] && !q.ctrl[CB_FLAG]) d.st = S_WAITFREE;
            end
            S_WAITFREE: begin
                if (tick && bus_free) begin
                    d.st  = S_START;
                    d.ph  = 2'd0;
                    d.rep = 1'b0;
                end
            end
            S_START: begin
                if (tick) begin
                    d.ph = q.ph + 2'd1;
                    case (q.ph)
                        2'd0: d.sda_oe = 1'b0;
                        2'd1: if (q.rep) d.scl_oe = 1'b0; else d.sda_oe = 1'b1;
                        2'd2: if (q.rep) d.sda_oe = 1'b1;
                        default: begin
                            d.scl_oe        = 1'b1;
                            d.st            = S_HOLD;
                            d.code          = q.rep ? ST_RSTART : ST_START;
                            d.ctrl[CB_FLAG] = 1'b1;
                        end
                    endcase
                end
            end
            S_SEND: begin
                if (tick) begin
                    d.ph = q.ph + 2'd1;
                    case (q.ph)
                        2'd0: d.sda_oe = (q.bidx == 4'd8) ? 1'b0 : !q.shreg[7];
                        2'd1: d.scl_oe = 1'b0;
                        2'd2: begin
                            if (q.bidx == 4'd8) begin
                                d.ackd = !sda_i;
                            end else begin
                                d.shreg = {q.shreg[6:0], 1'b0};
                                if (q.shreg[7] && !sda_i) begin
                                    d.st            = S_LOST;
                                    d.scl_oe        = 1'b0;
                                    d.sda_oe        = 1'b0;
                                    d.code          = ST_LOST;
                                    d.ctrl[CB_FLAG] = 1'b1;
                                end
                            end
                        end
                        default: begin
                            d.scl_oe = 1'b1;
                            if (q.bidx != 4'd8) begin
                                d.bidx = q.bidx + 4'd1;
                            end else if (q.is_addr && q.rd_addr) begin
                                d.st = S_RXPARK;
                                d.rx = 1'b1;
                            end else begin
                                d.st            = S_HOLD;
                                d.ctrl[CB_FLAG] = 1'b1;
                                if (q.is_addr) d.code = q.ackd ? ST_AACK : ST_ANACK;
                                else           d.code = q.ackd ? ST_DACK : ST_DNACK;
                            end
                        end
                    endcase
                end
            end
            S_HOLD: begin
                if (tick && !q.ctrl[CB_FLAG]) begin
                    d.ph = 2'd0;
                    if (q.code == ST_START || q.code == ST_RSTART) begin
                        d.st      = S_SEND;
                        d.bidx    = 4'd0;
                        d.shreg   = q.data;
                        d.is_addr = 1'b1;
                        d.rd_addr = q.data[0];
                    end else if (q.ctrl[CB_STOP]) begin
                        d.st            = S_STOP;
                        d.ctrl[CB_STOP] = 1'b0;
                    end else if (q.ctrl[CB_START]) begin
                        d.st  = S_START;
                        d.rep = 1'b1;
                    end else begin
                        d.st      = S_SEND;
                        d.bidx    = 4'd0;
                        d.shreg   = q.data;
                        d.is_addr = 1'b0;
                        d.rd_addr = 1'b0;
                    end
                end
            end
            S_STOP: begin
                if (tick) begin
                    d.ph = q.ph + 2'd1;
                    case (q.ph)
                        2'd0: d.sda_oe = 1'b1;
                        2'd1: d.scl_oe = 1'b0;
                        2'd2: d.sda_oe = 1'b0;
                        default: d.st = q.ctrl[CB_START] ? S_WAITFREE : S_IDLE;
                    endcase
                end
            end
            S_LOST: begin
                d.scl_oe = 1'b0;
                d.sda_oe = 1'b0;
                if (!q.ctrl[CB_FLAG]) d.st = q.ctrl[CB_START] ? S_WAITFREE : S_IDLE;
            end
            S_RXPARK: begin
                if (tick && q.ctrl[CB_STOP]) begin
                    d.st            = S_STOP;
                    d.ph            = 2'd0;
                    d.rx            = 1'b0;
                    d.ctrl[CB_STOP] = 1'b0;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.code <= ST_NONE;
        end else begin
            q <= d;
        end
    end

    assign irq_o     = q.ctrl[CB_FLAG];
    assign status_o  = q.ctrl[CB_FLAG] ? q.code : ST_NONE;
    assign ctrl_o    = q.ctrl;
    assign rx_mode_o = q.rx;
    assign scl_oe_o  = q.scl_oe;
    assign sda_oe_o  = q.sda_oe;
endmodule

// File: rtl/i2cm_xmit_chk.sv
module i2cm_xmit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] status_o,
    input logic       irq_o,
    input logic       rx_mode_o,
    input logic       scl_oe_o,
    input logic       sda_oe_o
);
    // R5
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_o == 8'h08 || status_o == 8'h10 || status_o == 8'h18 ||
                   status_o == 8'h20 || status_o == 8'h28 || status_o == 8'h30 ||
                   status_o == 8'h38));

    // R8
    stall_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && status_o != 8'h38) |-> scl_oe_o);

    // R10
    lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && status_o == 8'h38) |-> (!scl_oe_o && !sda_oe_o));

    // R9
    rx_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_mode_o |-> (scl_oe_o && !irq_o));
endmodule

bind i2cm_xmit i2cm_xmit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .status_o(status_o), .irq_o(irq_o),
    .rx_mode_o(rx_mode_o), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
);

// File: tb/sim_i2cm_xmit.sv
module sim_i2cm_xmit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] status_o;
    logic [3:0] ctrl_o;
    logic       irq_o, rx_mode_o, scl_oe_o, sda_oe_o;
    logic       scl_w, sda_w;
    logic       sl_drv = 1'b0;
    logic       sl_nack = 1'b0;
    logic       rival = 1'b0;
    logic [7:0] sl_sh = 8'h00;
    logic [7:0] sl_got = 8'h00;
    int         sl_cnt = 0;
    int         nchk = 0;
    int         nerr = 0;

    always #5 clk = ~clk;

    assign scl_w = ~scl_oe_o;
    assign sda_w = ~(sda_oe_o | sl_drv | rival);

    i2cm_xmit #(.QDIV(4)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .status_o(status_o), .ctrl_o(ctrl_o), .irq_o(irq_o), .rx_mode_o(rx_mode_o),
        .scl_i(scl_w), .sda_i(sda_w), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
    );

    // responding target: counts bits, acknowledges or not, records each byte
    always @(negedge sda_w) if (scl_w === 1'b1) sl_cnt = 0;
    always @(posedge scl_w) begin
        if (sl_cnt < 8) sl_sh = {sl_sh[6:0], sda_w};
        if (sl_cnt < 9) sl_cnt = sl_cnt + 1;
    end
    always @(negedge scl_w) begin
        if (sl_cnt == 8) sl_drv = !sl_nack;
        else if (sl_cnt == 9) begin
            sl_drv = 1'b0;
            sl_got = sl_sh;
            sl_cnt = 0;
        end
    end

    // fields: wait, chkbyte, nack, start, stop, data, expected status
    localparam int NV = 10;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h08},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA0, 8'h18},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h55, 8'h28},
        {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, 8'h30},
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h10},
        {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA4, 8'h20},
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h08},
        {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hB2, 8'h18},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hC3, 8'h28},
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hF8}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_irq();
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (irq_o) break;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", status_o, 8'hF8);
        chk("R1 ctrl", {4'h0, ctrl_o}, 8'h00);
        chk("R1 lines", {6'd0, scl_oe_o, sda_oe_o}, 8'h00);
        chk("R1 rx", {7'd0, rx_mode_o}, 8'h00);
        // R2 writing 1 to the flag does not set it
        wr(1'b0, 8'h02);
        idle(40);
        chk("R2 flag not settable", {4'h0, ctrl_o}, 8'h00);

        // R3 R4 R5 R6 R7 vector walk
        for (int i = 0; i < NV; i++) begin
            logic [20:0] v;
            v = VEC[i];
            sl_nack = v[18];
            wr(1'b1, v[15:8]);
            wr(1'b0, {4'h0, v[17], v[16], 1'b0, 1'b0});
            if (v[20]) begin
                wait_irq();
                chk($sformatf("R5/R6 vec %0d status", i), status_o, v[7:0]);
            end else begin
                idle(200);
                chk($sformatf("R6 vec %0d idle status", i), status_o, v[7:0]);
                chk("R7 stop bit cleared", {7'd0, ctrl_o[2]}, 8'h00);
                chk("R6 lines released", {6'd0, scl_oe_o, sda_oe_o}, 8'h00);
            end
            if (v[19]) chk($sformatf("R4 vec %0d byte on bus", i), sl_got, v[15:8]);
        end

        // R8 stall holds; writing flag=1 does not release
        sl_nack = 1'b0;
        wr(1'b0, 8'h08);
        wait_irq();
        chk("R3 start again", status_o, 8'h08);
        wr(1'b0, 8'h02);
        idle(100);
        chk("R8 still stalled", status_o, 8'h08);
        chk("R8 scl held", {7'd0, scl_oe_o}, 8'h01);

        // R12 ack enable has no effect
        wr(1'b1, 8'hA0);
        wr(1'b0, 8'h01);
        wait_irq();
        chk("R12 status", status_o, 8'h18);
        chk("R12 readback", {4'h0, ctrl_o}, 8'h03);
        chk("R12 byte", sl_got, 8'hA0);

        // R9 address with read bit after repeated start
        wr(1'b0, 8'h08);
        wait_irq();
        chk("R6 repeated start", status_o, 8'h10);
        wr(1'b1, 8'hA1);
        wr(1'b0, 8'h00);
        idle(250);
        chk("R9 rx", {7'd0, rx_mode_o}, 8'h01);
        chk("R9 status", status_o, 8'hF8);
        chk("R9 scl held", {7'd0, scl_oe_o}, 8'h01);
        wr(1'b0, 8'h04);
        idle(200);
        chk("R9 rx dropped", {7'd0, rx_mode_o}, 8'h00);
        chk("R7 stop bit cleared", {7'd0, ctrl_o[2]}, 8'h00);
        chk("R9 lines released", {6'd0, scl_oe_o, sda_oe_o}, 8'h00);

        // R10 arbitration loss, then R11 start=1 waits for free bus
        wr(1'b0, 8'h08);
        wait_irq();
        chk("R3 start", status_o, 8'h08);
        rival = 1'b1;
        wr(1'b1, 8'hA0);
        wr(1'b0, 8'h00);
        wait_irq();
        chk("R10 status", status_o, 8'h38);
        chk("R10 lines released", {6'd0, scl_oe_o, sda_oe_o}, 8'h00);
        wr(1'b0, 8'h08);
        idle(150);
        chk("R11 waits for free bus", {7'd0, sda_oe_o}, 8'h00);
        chk("R11 no flag while waiting", {7'd0, irq_o}, 8'h00);
        rival = 1'b0;
        wait_irq();
        chk("R11 start after free", status_o, 8'h08);

        // R11 start=0 returns to idle
        rival = 1'b1;
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'h00);
        wait_irq();
        chk("R10 second loss", status_o, 8'h38);
        rival = 1'b0;
        wr(1'b0, 8'h00);
        idle(100);
        chk("R11 idle status", status_o, 8'hF8);
        chk("R11 idle lines", {6'd0, scl_oe_o, sda_oe_o}, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule